// File: doc/BRIEF.md
# HDB3 Line Decoder with Double-Violation Detection

This block turns a bipolar HDB3 line signal into a plain NRZ bit stream. The line arrives as two unipolar rails, one for positive pulses and one for negative pulses, sampled on a recovered bit clock. Every pulse is sorted into one of two kinds. A mark is a pulse of the opposite polarity to the pulse before it. A violation is a pulse of the same polarity as the pulse before it.

Violations show where the encoder put a substitution in place of four zeros. The decoder removes each substitution inside a short output pipeline. Its output therefore follows the rail inputs by a fixed number of clocks. The decoder also records which rail carried the most recent violation. When a new violation arrives on that same rail, it raises a one-clock error pulse. This pulse is a line-code error indication for the framer that follows.

Top module: `hdb3_line_decoder`

## Requirements
- R1: A pulse that is a mark on either rail, sampled at clock edge n, appears as a 1 on `nrz_out` after edge n+5. It stays there for exactly one clock.
- R2: A bit period with no pulse on either rail decodes to 0 at the same latency.
- R3: A single-rail pulse whose polarity matches the preceding single-rail pulse is a violation. Its own bit position decodes to 0.
- R4: When a violation is classified, the bit sampled three periods before it is forced to 0. This removes the leading mark of a B00V pattern and leaves a 000V pattern as four zeros.
- R5: A pulse on both rails in the same period is a code error. It decodes to 1 and does not change the recorded polarity of the last pulse.
- R6: A violation whose polarity matches the previous violation makes `dbl_viol` high for exactly one clock. The pulse begins at the edge after the edge that classified the violation, so it appears after edge n+1 for a violation sampled at edge n.
- R7: Reset clears both the last-pulse record and the last-violation record. After reset, the first pulse is never a violation, and the first violation never raises `dbl_viol`.
- R8: While `rst` is high, `nrz_out` and `dbl_viol` are 0 at every edge, and rail activity is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rail_pos | input | 1 | Positive-pulse rail, high for one bit period per pulse |
| rail_neg | input | 1 | Negative-pulse rail, high for one bit period per pulse |
| nrz_out | output | 1 | Decoded data, five clocks behind the rails |
| dbl_viol | output | 1 | One-clock pulse for two successive violations of equal polarity |

## Verification
The hardest case to reach from the ports is a violation whose polarity matches the previous violation. A correct encoder never produces this, so a clean line stream cannot reach it. Bursts such as a run of same-rail pulses, or a code error placed between two equal pulses, push the two polarity records into it directly. The first violation after reset and the B00V cancellation reaching back three positions are reached by opening the run with a hand-built prefix. That prefix is followed by an encoder-generated stream of every 8-bit pattern, and then by random four-symbol line noise.

// File: rtl/hdb3_dec_pkg.sv
package hdb3_dec_pkg;

    // Clocks from rail capture to the NRZ output register.
    localparam int unsigned LINE_LATENCY = 5;
    // Distance from a violation back to the pulse a B00V group adds.
    localparam int unsigned SUBST_GAP    = 3;

    // Bit 0 is the positive rail and bit 1 is the negative rail.
    typedef enum logic [1:0] {
        SYM_SPACE = 2'b00,
        SYM_POS   = 2'b01,
        SYM_NEG   = 2'b10,
        SYM_BOTH  = 2'b11
    } line_sym_e;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_e;

    typedef struct packed {
        logic valid;
        pol_e pol;
    } pol_rec_t;

    typedef struct packed {
        logic data;     // decoded bit for this position
        logic viol;     // position classified as a violation
        logic dbl;      // violation repeats the last violation polarity
    } sym_class_t;

    function automatic line_sym_e rails_to_sym(input logic p, input logic n);
        return line_sym_e'({n, p});
    endfunction

    function automatic logic is_single(input line_sym_e s);
        return (s == SYM_POS) || (s == SYM_NEG);
    endfunction

    function automatic pol_e sym_pol(input line_sym_e s);
        return (s == SYM_POS) ? POL_POS : POL_NEG;
    endfunction

endpackage

// File: rtl/hdb3_rail_capture.sv
module hdb3_rail_capture
    import hdb3_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rail_pos,
    input  logic      rail_neg,
    output line_sym_e sym_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= SYM_SPACE;
        end else begin
            sym_q <= rails_to_sym(rail_pos, rail_neg);
        end
    end

endmodule

// File: rtl/hdb3_violation_tracker.sv
module hdb3_violation_tracker
    import hdb3_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_sym_e  sym,
    output sym_class_t cls
);

    pol_rec_t last_mark_q;
    pol_rec_t last_viol_q;
    logic     single;
    pol_e     cur_pol;

    always_comb begin
        single   = is_single(sym);
        cur_pol  = sym_pol(sym);
        cls.viol = single && last_mark_q.valid && (last_mark_q.pol == cur_pol);
        cls.data = (sym != SYM_SPACE) && !cls.viol;
        cls.dbl  = cls.viol && last_viol_q.valid && (last_viol_q.pol == cur_pol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_mark_q <= '{valid: 1'b0, pol: POL_NEG};
            last_viol_q <= '{valid: 1'b0, pol: POL_NEG};
        end else begin
            if (single) begin
                last_mark_q <= '{valid: 1'b1, pol: cur_pol};
            end
            if (cls.viol) begin
                last_viol_q <= '{valid: 1'b1, pol: cur_pol};
            end
        end
    end

endmodule

// File: rtl/hdb3_zero_restore.sv
module hdb3_zero_restore #(
    parameter int unsigned STAGES = 4,
    parameter int unsigned GAP    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic data_in,
    input  logic cancel_back,
    output logic data_out
);

    logic [STAGES-1:0] pipe_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) pipe_q[i] <= 1'b0;
                else     pipe_q[i] <= data_in;
            end
        end else if (i == GAP) begin : g_cancel
            always_ff @(posedge clk) begin
                if (rst) pipe_q[i] <= 1'b0;
                else     pipe_q[i] <= pipe_q[i-1] & ~cancel_back;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) pipe_q[i] <= 1'b0;
                else     pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) data_out <= 1'b0;
        else     data_out <= pipe_q[STAGES-1];
    end

endmodule

// File: rtl/hdb3_line_decoder.sv
module hdb3_line_decoder
    import hdb3_dec_pkg::*;
#(
    parameter int unsigned LATENCY = LINE_LATENCY,
    parameter int unsigned GAP     = SUBST_GAP
) (
    input  logic clk,
    input  logic rst,
    input  logic rail_pos,
    input  logic rail_neg,
    output logic nrz_out,
    output logic dbl_viol
);

    localparam int unsigned STAGES = LATENCY - 1;

    line_sym_e  sym_q;
    sym_class_t cls;
    logic       viol_now;

    hdb3_rail_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .rail_pos (rail_pos),
        .rail_neg (rail_neg),
        .sym_q    (sym_q)
    );

    hdb3_violation_tracker u_tracker (
        .clk (clk),
        .rst (rst),
        .sym (sym_q),
        .cls (cls)
    );

    hdb3_zero_restore #(
        .STAGES (STAGES),
        .GAP    (GAP)
    ) u_restore (
        .clk         (clk),
        .rst         (rst),
        .data_in     (cls.data),
        .cancel_back (cls.viol),
        .data_out    (nrz_out)
    );

    assign viol_now = cls.viol;

    always_ff @(posedge clk) begin
        if (rst) dbl_viol <= 1'b0;
        else     dbl_viol <= cls.dbl;
    end

endmodule

// File: rtl/hdb3_line_decoder_checker.sv
module hdb3_line_decoder_checker (
    input logic clk,
    input logic rst,
    input logic rail_pos,
    input logic rail_neg,
    input logic nrz_out,
    input logic dbl_viol,
    input logic viol_now
);

    // R1: a 1 on the output needs a pulse on the rails six edges earlier.
    assert_one_has_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        nrz_out |-> $past(rail_pos | rail_neg, 6));

    // R3: the bit position of a violation leaves the pipeline as 0.
    assert_viol_bit_zero_R3: assert property (@(posedge clk) disable iff (rst)
        viol_now |-> ##5 !nrz_out);

    // R4: the position three bits before a violation leaves as 0.
    assert_back_cancel_R4: assert property (@(posedge clk) disable iff (rst)
        viol_now |-> ##2 !nrz_out);

    // R6: an error pulse comes from a single-rail pulse two edges earlier.
    assert_dbl_from_single_R6: assert property (@(posedge clk) disable iff (rst)
        dbl_viol |-> $past(rail_pos ^ rail_neg, 2));

    // R8: reset clears both outputs at the next edge.
    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |=> (!nrz_out && !dbl_viol));

endmodule

bind hdb3_line_decoder hdb3_line_decoder_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rail_pos (rail_pos),
    .rail_neg (rail_neg),
    .nrz_out  (nrz_out),
    .dbl_viol (dbl_viol),
    .viol_now (viol_now)
);

// File: tb/hdb3_line_decoder_tb.sv
module hdb3_line_decoder_tb;

    localparam int N_HAND  = 24;
    localparam int N_CLEAN = 2048;
    localparam int N_RAND  = 1500;
    localparam int N       = N_HAND + N_CLEAN + N_RAND;

    // Symbol code: bit 0 = positive rail, bit 1 = negative rail.
    localparam logic [1:0] HAND [N_HAND] = '{
        2'd1, 2'd0, 2'd0, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0,
        2'd2, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1, 2'd3,
        2'd1, 2'd1, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rail_pos = 1'b0;
    logic rail_neg = 1'b0;
    logic nrz_out;
    logic dbl_viol;

    logic [1:0] sym_a   [N];
    bit         exp_bit [N];
    bit         exp_err [N];
    bit         first_v [N];
    int         kind    [N];   // 0 space, 1 mark, 2 violation, 3 cancelled, 4 both rails

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hdb3_line_decoder u_dut (
        .clk      (clk),
        .rst      (rst),
        .rail_pos (rail_pos),
        .rail_neg (rail_neg),
        .nrz_out  (nrz_out),
        .dbl_viol (dbl_viol)
    );

    task automatic check(input string tag, input int idx, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at index %0d: actual %0b expected %0b", tag, idx, act, exp);
        end
    endtask

    function automatic string bit_tag(input int k);
        case (k)
            1:       return "R1";
            2:       return "R3";
            3:       return "R4";
            4:       return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic build_stream();
        bit last_pol = 1'b0;
        int marks = 0;
        int zrun = 0;
        bit mv = 1'b0, mp = 1'b0, vv = 1'b0, vp = 1'b0;
        for (int i = 0; i < N_HAND; i++) sym_a[i] = HAND[i];
        // Clean stream from an HDB3 encoder over every 8-bit pattern.
        for (int i = 0; i < N_CLEAN; i++) begin
            int  pos = N_HAND + i;
            bit  d = ((i / 8) >> (i % 8)) & 1;
            if (d) begin
                last_pol = ~last_pol;
                sym_a[pos] = last_pol ? 2'd1 : 2'd2;
                marks++;
                zrun = 0;
            end else begin
                sym_a[pos] = 2'd0;
                zrun++;
                if (zrun == 4) begin
                    if (marks % 2 == 0) begin
                        last_pol = ~last_pol;
                        sym_a[pos-3] = last_pol ? 2'd1 : 2'd2;
                    end
                    sym_a[pos] = last_pol ? 2'd1 : 2'd2;
                    marks = 0;
                    zrun = 0;
                end
            end
        end
        for (int i = 0; i < N_RAND; i++) sym_a[N_HAND+N_CLEAN+i] = 2'($urandom_range(0, 3));
        // Expected decoding from the requirements.
        for (int i = 0; i < N; i++) begin
            exp_bit[i] = 1'b0; exp_err[i] = 1'b0; first_v[i] = 1'b0; kind[i] = 0;
            if (sym_a[i] == 2'd3) begin
                exp_bit[i] = 1'b1; kind[i] = 4;
            end else if (sym_a[i] != 2'd0) begin
                bit p = (sym_a[i] == 2'd1);
                if (mv && mp == p) begin
                    kind[i] = 2;
                    if (i >= 3) begin
                        if (exp_bit[i-3]) kind[i-3] = 3;
                        exp_bit[i-3] = 1'b0;
                    end
                    if (vv && vp == p) exp_err[i] = 1'b1;
                    if (!vv) first_v[i] = 1'b1;
                    vv = 1'b1; vp = p;
                end else begin
                    exp_bit[i] = 1'b1; kind[i] = 1;
                end
                mv = 1'b1; mp = p;
            end
        end
    endtask

    initial begin
        build_stream();
        // Reset with rail activity that must be ignored (R8).
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            rail_pos = r[0];
            rail_neg = ~r[0];
            if (r > 0) begin
                check("R8 nrz in reset", r, nrz_out, 1'b0);
                check("R8 dbl in reset", r, dbl_viol, 1'b0);
            end
        end
        for (int k = 0; k < N + 7; k++) begin
            @(negedge clk);
            rst = 1'b0;
            rail_pos = (k < N) ? sym_a[k][0] : 1'b0;
            rail_neg = (k < N) ? sym_a[k][1] : 1'b0;
            if (k >= 6 && k - 6 < N)
                check(bit_tag(kind[k-6]), k - 6, nrz_out, exp_bit[k-6]);
            else if (k < 6)
                check("R8 drained", k, nrz_out, 1'b0);
            if (k >= 2 && k - 2 < N)
                check((first_v[k-2] && !exp_err[k-2]) ? "R7" : "R6", k - 2, dbl_viol, exp_err[k-2]);
            else if (k < 2)
                check("R7 no flag", k, dbl_viol, 1'b0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule